// File: doc/BRIEF.md
# Hybrid Multilevel Staircase-PWM Modulator

This block turns one signed reference sample per clock into level commands for every cell of one phase of an asymmetric cascaded multilevel inverter. The cells are ordered from the smallest voltage step (cell 0, fixed at 1 p.u.) to the largest. Every cell above cell 0 quantizes its own reference against a fixed staircase of thresholds and so changes state only at the stepped, fundamental rate. The part of its reference that it could not produce is passed down as the reference of the next smaller cell. Cell 0 is the only carrier-modulated cell. It compares the last residual with an internal triangle carrier and switches at the carrier rate.

All levels are reported in half-p.u. units, so that cells with an even level count, whose outputs sit at odd multiples of V/2, stay integers. The reference `ref_i` is a two's-complement value in p.u. with `FRAC_W` fraction bits. Cell count, level counts and integer steps are elaboration parameters, and they are checked when the block is built. Every output is registered, so an output reflects the reference and carrier value sampled at the previous clock edge. The default configuration has cells of 2, 3 and 5 levels with steps of 1, 1 and 3 p.u. It gives 16 phase levels, from -7.5 p.u. to +7.5 p.u.

Top module: `hml_modulator`

## Requirements
- R1: While `rst_n` is low, every cell output and the phase output are 0. The carrier restarts at 0 and rises after reset is released.
- R2: `phase_half_o` equals the sum of all cell outputs of the same cycle, one clock after the reference is sampled.
- R3: For a cell j ≥ 1 with an odd level count m and step V, let 2σ = sum over the lower cells k of (m_k−1)·V_k. The thresholds, in half-p.u., are 2σ + 2(i−1)V for i = 1..(m−1)/2. The output is 2V times the number of thresholds that |reference| strictly exceeds, with the sign of the reference.
- R4: For a cell j ≥ 1 with an even level count, the thresholds are 2σ + (2i−1)V for i = 1..(m−2)/2. The output magnitude is V·(2c+1), where c is the number of thresholds exceeded, so the output is never 0. A zero reference counts as positive.
- R5: The reference of cell j−1 is the reference of cell j minus the present output of cell j, and the top cell's reference is `ref_i`.
- R6: A two-level cell 0 outputs +1 (half-p.u.) when its reference is strictly greater than the carrier, and −1 otherwise.
- R7: A three-level cell 0 outputs +2 when its reference is above the carrier plus 0.5 p.u. It outputs −2 when its reference is below the carrier minus 0.5 p.u., and 0 otherwise.
- R8: The carrier moves by `CAR_INC` fixed-point steps each clock. It reverses direction on reaching +0.5 p.u. or −0.5 p.u.
- R9: While `ref_i` is held constant, all cells above cell 0 hold their outputs, and the phase output moves by at most one level per clock.
- R10: A reference beyond the phase span drives the phase output to its extreme level, ±2σ_total half-p.u. This is ±15 in the default configuration.
- R11: `phase_half_o` never leaves the range −2σ_total … +2σ_total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | REF_W | Signed reference in p.u., FRAC_W fraction bits |
| cell_half_o | output | NCELL*LVL_W | Per-cell signed level in half-p.u.; cell j in bits [j*LVL_W +: LVL_W] |
| phase_half_o | output | LVL_W | Signed phase level in half-p.u. |

## Verification
A threshold or residual error in a higher cell shows up in the next cycle. It appears as a wrong cell level, and also as a wrong level in every cell below, because the faulty residual passes down the chain. A carrier that drifts, or that turns at the wrong point, cannot be seen with a fixed reference until cell 0 changes state at the wrong clock. The bench compares every clock against a model that tracks the carrier from reset, so such a fault is reported at the first misplaced edge of cell 0. Holding the reference steady and driving it into saturation separate the stepped cells from the carrier-driven cell.

// File: rtl/hml_pkg.sv
package hml_pkg;

   localparam int MAX_CELLS = 8;

   // Per-cell configuration list; entries at or above the cell count are ignored.
   typedef int cell_cfg_t [MAX_CELLS];

   typedef enum logic {
      CAR_RISE = 1'b0,
      CAR_FALL = 1'b1
   } car_dir_e;

   // Twice the half-span of cells 0..upto-1, in half-p.u. units.
   function automatic int span2(cell_cfg_t lv, cell_cfg_t st, int upto);
      int acc;
      acc = 0;
      for (int k = 0; k < MAX_CELLS; k++) begin
         if (k < upto) acc += (lv[k] - 1) * st[k];
      end
      return acc;
   endfunction

   // Number of staircase thresholds of a cell with lv levels.
   function automatic int thr_count(int lv);
      return (lv % 2 == 1) ? (lv - 1) / 2 : (lv - 2) / 2;
   endfunction

endpackage

// File: rtl/hml_carrier.sv
module hml_carrier
   import hml_pkg::*;
#(
   parameter int W   = 20,
   parameter int AMP = 256,
   parameter int INC = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic signed [W-1:0] car_o
);

   localparam logic signed [W-1:0] AMP_S = W'(AMP);
   localparam logic signed [W-1:0] INC_S = W'(INC);

   logic signed [W-1:0] car_q;
   logic signed [W-1:0] car_d;
   car_dir_e            dir_q;
   car_dir_e            dir_d;

   always_comb begin
      dir_d = dir_q;
      if (dir_q == CAR_RISE) begin
         car_d = car_q + INC_S;
         if (car_d >= AMP_S) dir_d = CAR_FALL;
      end else begin
         car_d = car_q - INC_S;
         if (car_d <= -AMP_S) dir_d = CAR_RISE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         car_q <= '0;
         dir_q <= CAR_RISE;
      end else begin
         car_q <= car_d;
         dir_q <= dir_d;
      end
   end

   assign car_o = car_q;

endmodule

// File: rtl/hml_stair_cell.sv
module hml_stair_cell
   import hml_pkg::*;
#(
   parameter int W      = 20,
   parameter int FRAC_W = 8,
   parameter int LVL_W  = 8,
   parameter int LEVELS = 3,
   parameter int STEP   = 1,
   parameter int BASE2  = 0
) (
   input  logic signed [W-1:0]     ref_i,
   output logic signed [LVL_W-1:0] lvl_o,
   output logic signed [W-1:0]     resid_o
);

   localparam int NTH   = thr_count(LEVELS);
   localparam int HIT_N = (NTH > 0) ? NTH : 1;
   localparam int CNT_W = $clog2(HIT_N + 1);
   localparam bit ODD   = (LEVELS % 2) == 1;

   logic                     neg;
   logic [W-1:0]             mag;
   logic [HIT_N-1:0]         hit;
   logic [CNT_W-1:0]         cnt;
   logic [LVL_W-1:0]         size;
   logic signed [W-1:0]      lvl_fx;

   assign neg = ref_i[W-1];
   assign mag = neg ? $unsigned(-ref_i) : $unsigned(ref_i);

   generate
      if (NTH == 0) begin : g_no_thr
         assign hit = '0;
      end else begin : g_thr
         for (genvar i = 0; i < NTH; i++) begin : g_cmp
            localparam int TH_HALF = ODD ? BASE2 + 2 * i * STEP
                                         : BASE2 + (2 * i + 1) * STEP;
            localparam logic [W-1:0] TH_FX = W'(TH_HALF) << FRAC_W;
            assign hit[i] = mag > TH_FX;
         end
      end
   endgenerate

   assign cnt = CNT_W'($countones(hit));

   generate
      if (ODD) begin : g_odd
         assign size = LVL_W'(2 * STEP) * LVL_W'(cnt);
      end else begin : g_even
         assign size = LVL_W'(STEP) * ((LVL_W'(cnt) << 1) + LVL_W'(1));
      end
   endgenerate

   assign lvl_o   = neg ? -$signed(size) : $signed(size);
   assign lvl_fx  = W'(lvl_o) <<< FRAC_W;
   assign resid_o = ref_i - lvl_fx;

endmodule

// File: rtl/hml_pwm_cell.sv
module hml_pwm_cell #(
   parameter int W      = 20,
   parameter int FRAC_W = 8,
   parameter int LVL_W  = 8,
   parameter int LEVELS = 2
) (
   input  logic signed [W-1:0]     ref_i,
   input  logic signed [W-1:0]     car_i,
   output logic signed [LVL_W-1:0] lvl_o
);

   localparam logic signed [LVL_W-1:0] POS1 = 1;
   localparam logic signed [LVL_W-1:0] NEG1 = -1;
   localparam logic signed [LVL_W-1:0] POS2 = 2;
   localparam logic signed [LVL_W-1:0] NEG2 = -2;
   localparam logic signed [LVL_W-1:0] ZERO = 0;
   localparam logic signed [W-1:0]     HALF_FX = W'(1) <<< FRAC_W;

   generate
      if (LEVELS == 2) begin : g_two
         assign lvl_o = (ref_i > car_i) ? POS1 : NEG1;
      end else begin : g_three
         logic signed [W-1:0] up_th;
         logic signed [W-1:0] dn_th;
         assign up_th = car_i + HALF_FX;
         assign dn_th = car_i - HALF_FX;
         assign lvl_o = (ref_i > up_th) ? POS2 :
                        (ref_i < dn_th) ? NEG2 : ZERO;
      end
   endgenerate

endmodule

// File: rtl/hml_modulator.sv
module hml_modulator
   import hml_pkg::*;
#(
   parameter int        NCELL       = 3,
   parameter cell_cfg_t CELL_LEVELS = '{2, 3, 5, 0, 0, 0, 0, 0},
   parameter cell_cfg_t CELL_STEPS  = '{1, 1, 3, 0, 0, 0, 0, 0},
   parameter int        REF_W       = 16,
   parameter int        FRAC_W      = 8,
   parameter int        LVL_W       = 8,
   parameter int        CAR_INC     = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [REF_W-1:0]  ref_i,
   output logic [NCELL*LVL_W-1:0]   cell_half_o,
   output logic signed [LVL_W-1:0]  phase_half_o
);

   localparam int W       = REF_W + 4;
   localparam int STOT    = span2(CELL_LEVELS, CELL_STEPS, NCELL);
   localparam int CAR_AMP = 2 ** FRAC_W;

   // Elaboration checks on the configuration.
   generate
      if (NCELL < 2 || NCELL > MAX_CELLS) begin : g_bad_ncell
         $error("cell count out of range");
      end
      if (CELL_STEPS[0] != 1) begin : g_bad_base
         $error("lowest cell step must be 1");
      end
      if (CELL_LEVELS[0] != 2 && CELL_LEVELS[0] != 3) begin : g_bad_low
         $error("lowest cell must have 2 or 3 levels");
      end
      if (CAR_INC < 1 || (CAR_AMP % CAR_INC) != 0) begin : g_bad_inc
         $error("carrier increment must divide the carrier amplitude");
      end
      if (LVL_W + FRAC_W > REF_W + 2) begin : g_bad_fx
         $error("level width too wide for the reference format");
      end
      if (STOT >= 2 ** (LVL_W - 1)) begin : g_bad_lvlw
         $error("level width too narrow for the phase span");
      end
      for (genvar j = 1; j < NCELL; j++) begin : g_cfg
         if (CELL_LEVELS[j] < 2) begin : g_bad_lv
            $error("cell needs at least 2 levels");
         end
         if (CELL_STEPS[j] < CELL_STEPS[j-1]) begin : g_bad_order
            $error("cell steps must not decrease");
         end
         if (CELL_STEPS[j] > 1 + span2(CELL_LEVELS, CELL_STEPS, j)) begin : g_bad_gap
            $error("cell step leaves a gap in the output levels");
         end
      end
   endgenerate

   logic signed [W-1:0]     chain [NCELL];
   logic signed [LVL_W-1:0] lvl_d [NCELL];
   logic signed [LVL_W-1:0] lvl_q [NCELL];
   logic signed [LVL_W-1:0] phase_d;
   logic signed [LVL_W-1:0] phase_q;
   logic signed [W-1:0]     car;

   assign chain[NCELL-1] = W'(ref_i) <<< 1;

   hml_carrier #(
      .W   (W),
      .AMP (CAR_AMP),
      .INC (CAR_INC)
   ) u_carrier (
      .clk   (clk),
      .rst_n (rst_n),
      .car_o (car)
   );

   generate
      for (genvar j = 1; j < NCELL; j++) begin : g_stair
         hml_stair_cell #(
            .W      (W),
            .FRAC_W (FRAC_W),
            .LVL_W  (LVL_W),
            .LEVELS (CELL_LEVELS[j]),
            .STEP   (CELL_STEPS[j]),
            .BASE2  (span2(CELL_LEVELS, CELL_STEPS, j))
         ) u_cell (
            .ref_i   (chain[j]),
            .lvl_o   (lvl_d[j]),
            .resid_o (chain[j-1])
         );
      end
   endgenerate

   hml_pwm_cell #(
      .W      (W),
      .FRAC_W (FRAC_W),
      .LVL_W  (LVL_W),
      .LEVELS (CELL_LEVELS[0])
   ) u_low (
      .ref_i (chain[0]),
      .car_i (car),
      .lvl_o (lvl_d[0])
   );

   always_comb begin
      phase_d = '0;
      for (int j = 0; j < NCELL; j++) phase_d = phase_d + lvl_d[j];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < NCELL; j++) lvl_q[j] <= '0;
         phase_q <= '0;
      end else begin
         for (int j = 0; j < NCELL; j++) lvl_q[j] <= lvl_d[j];
         phase_q <= phase_d;
      end
   end

   generate
      for (genvar j = 0; j < NCELL; j++) begin : g_out
         assign cell_half_o[j*LVL_W +: LVL_W] = lvl_q[j];
      end
   endgenerate

   assign phase_half_o = phase_q;

endmodule

// File: rtl/hml_modulator_chk.sv
module hml_modulator_chk
   import hml_pkg::*;
#(
   parameter int        NCELL       = 3,
   parameter cell_cfg_t CELL_LEVELS = '{2, 3, 5, 0, 0, 0, 0, 0},
   parameter cell_cfg_t CELL_STEPS  = '{1, 1, 3, 0, 0, 0, 0, 0},
   parameter int        REF_W       = 16,
   parameter int        LVL_W       = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic signed [REF_W-1:0] ref_i,
   input logic [NCELL*LVL_W-1:0]  cell_half_o,
   input logic signed [LVL_W-1:0] phase_half_o
);

   localparam int STOT = span2(CELL_LEVELS, CELL_STEPS, NCELL);
   localparam int SW   = LVL_W + 4;

   logic [1:0]              age_q;
   logic                    primed;
   logic signed [LVL_W-1:0] prev_q;
   logic signed [SW-1:0]    cell_sum;
   logic signed [SW-1:0]    delta;
   logic signed [LVL_W-1:0] low_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_q  <= '0;
         prev_q <= '0;
      end else begin
         if (age_q != 2'd2) age_q <= age_q + 2'd1;
         prev_q <= phase_half_o;
      end
   end

   assign primed  = (age_q == 2'd2);
   assign delta   = SW'(phase_half_o) - SW'(prev_q);
   assign low_lvl = $signed(cell_half_o[LVL_W-1:0]);

   always_comb begin
      cell_sum = '0;
      for (int j = 0; j < NCELL; j++)
         cell_sum = cell_sum + SW'($signed(cell_half_o[j*LVL_W +: LVL_W]));
   end

   assert_phase_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
      SW'(phase_half_o) == cell_sum);

   assert_phase_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_half_o <= STOT) && (phase_half_o >= -STOT));

   assert_one_level_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $stable(ref_i)) |=> ((delta <= 2) && (delta >= -2)));

   generate
      for (genvar j = 1; j < NCELL; j++) begin : g_upper
         assert_upper_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && $stable(ref_i)) |=> $stable(cell_half_o[j*LVL_W +: LVL_W]));
         if (CELL_LEVELS[j] % 2 == 0) begin : g_even
            assert_even_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
               primed |-> (cell_half_o[j*LVL_W +: LVL_W] != '0));
         end
      end
      if (CELL_LEVELS[0] == 2) begin : g_low2
         assert_low_two_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> ((low_lvl == 1) || (low_lvl == -1)));
      end else begin : g_low3
         assert_low_three_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> ((low_lvl == 2) || (low_lvl == 0) || (low_lvl == -2)));
      end
   endgenerate

endmodule

bind hml_modulator hml_modulator_chk #(
   .NCELL       (NCELL),
   .CELL_LEVELS (CELL_LEVELS),
   .CELL_STEPS  (CELL_STEPS),
   .REF_W       (REF_W),
   .LVL_W       (LVL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ref_i        (ref_i),
   .cell_half_o  (cell_half_o),
   .phase_half_o (phase_half_o)
);

// File: tb/hml_modulator_test.sv
`timescale 1ns/1ps
module hml_modulator_test;
   import hml_pkg::*;

   localparam int FRAC = 8;
   localparam int INC  = 8;
   localparam int ONE  = 1 << FRAC;
   localparam cell_cfg_t LV_A = '{2, 3, 5, 0, 0, 0, 0, 0};
   localparam cell_cfg_t ST_A = '{1, 1, 3, 0, 0, 0, 0, 0};
   localparam cell_cfg_t LV_B = '{3, 4, 0, 0, 0, 0, 0, 0};
   localparam cell_cfg_t ST_B = '{1, 2, 0, 0, 0, 0, 0, 0};

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [15:0] ref_v = '0;
   logic [23:0]        cells_a;
   logic signed [7:0]  phase_a;
   logic [15:0]        cells_b;
   logic signed [7:0]  phase_b;

   int        errors = 0;
   int        checks = 0;
   bit        live = 1'b0;
   bit        done = 1'b0;
   cell_cfg_t exp_a = '{default: 0};
   cell_cfg_t exp_b = '{default: 0};
   int        mcar = 0;
   bit        mdown = 1'b0;

   always #4 clk = ~clk;

   hml_modulator uut (
      .clk (clk), .rst_n (rst_n), .ref_i (ref_v),
      .cell_half_o (cells_a), .phase_half_o (phase_a)
   );

   hml_modulator #(
      .NCELL (2), .CELL_LEVELS (LV_B), .CELL_STEPS (ST_B)
   ) uut_b (
      .clk (clk), .rst_n (rst_n), .ref_i (ref_v),
      .cell_half_o (cells_b), .phase_half_o (phase_b)
   );

   // Behavioural model of the cascade, all values in half-p.u.
   function automatic cell_cfg_t model_cells(cell_cfg_t lv, cell_cfg_t st, int n,
                                             int refv, int car);
      cell_cfg_t o;
      int r, base, mag, cnt, nth, th;
      o = '{default: 0};
      r = refv * 2;
      for (int j = n - 1; j >= 1; j--) begin
         base = 0;
         for (int k = 0; k < j; k++) base += (lv[k] - 1) * st[k];
         mag = (r < 0) ? -r : r;
         nth = (lv[j] % 2 == 1) ? (lv[j] - 1) / 2 : (lv[j] - 2) / 2;
         cnt = 0;
         for (int i = 1; i <= nth; i++) begin
            th = (lv[j] % 2 == 1) ? base + 2 * (i - 1) * st[j] : base + (2 * i - 1) * st[j];
            if (mag > th * ONE) cnt++;
         end
         o[j] = (lv[j] % 2 == 1) ? 2 * st[j] * cnt : st[j] * (2 * cnt + 1);
         if (r < 0) o[j] = -o[j];
         r -= o[j] * ONE;
      end
      if (lv[0] == 2) o[0] = (r > car) ? 1 : -1;
      else            o[0] = (r > car + ONE) ? 2 : ((r < car - ONE) ? -2 : 0);
      return o;
   endfunction

   function automatic string tag_of(cell_cfg_t lv, int j);
      if (j == 0) return (lv[0] == 2) ? "R6 R8" : "R7 R8";
      return (lv[j] % 2 == 1) ? "R3 R5" : "R4 R5";
   endfunction

   function automatic int cell_a(int j);
      return int'($signed(cells_a[j*8 +: 8]));
   endfunction

   function automatic int cell_b(int j);
      return int'($signed(cells_b[j*8 +: 8]));
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic check_reset();
      for (int j = 0; j < 3; j++) chk("R1", $sformatf("A cell%0d in reset", j), cell_a(j), 0);
      for (int j = 0; j < 2; j++) chk("R1", $sformatf("B cell%0d in reset", j), cell_b(j), 0);
      chk("R1", "A phase in reset", int'(phase_a), 0);
      chk("R1", "B phase in reset", int'(phase_b), 0);
   endtask

   task automatic hold(int value, int cycles);
      ref_v = 16'(value);
      repeat (cycles) tick();
   endtask

   // Expected values and carrier model, advanced at each active edge.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_a = '{default: 0};
         exp_b = '{default: 0};
         mcar  = 0;
         mdown = 1'b0;
      end else begin
         exp_a = model_cells(LV_A, ST_A, 3, int'(ref_v), mcar);
         exp_b = model_cells(LV_B, ST_B, 2, int'(ref_v), mcar);
         if (!mdown) begin
            mcar += INC;
            if (mcar >= ONE) mdown = 1'b1;
         end else begin
            mcar -= INC;
            if (mcar <= -ONE) mdown = 1'b0;
         end
      end
   end

   // Every-clock comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (live && rst_n) begin
         int sa, sb;
         sa = 0;
         sb = 0;
         for (int j = 0; j < 3; j++) begin
            chk(tag_of(LV_A, j), $sformatf("A cell%0d", j), cell_a(j), exp_a[j]);
            sa += exp_a[j];
         end
         for (int j = 0; j < 2; j++) begin
            chk(tag_of(LV_B, j), $sformatf("B cell%0d", j), cell_b(j), exp_b[j]);
            sb += exp_b[j];
         end
         chk("R2", "A phase", int'(phase_a), sa);
         chk("R2", "B phase", int'(phase_b), sb);
         chk("R11", "A phase in range", int'(phase_a >= -15 && phase_a <= 15), 1);
         chk("R11", "B phase in range", int'(phase_b >= -8 && phase_b <= 8), 1);
      end
   end

   initial begin
      int h1, h2, hb, prev;
      repeat (3) tick();
      live = 1'b1;
      check_reset();
      rst_n = 1'b1;

      hold(0, 200);
      hold(512, 200);
      hold(-845, 200);
      hold(1894, 200);
      hold(-1100, 200);

      // R9: constant reference keeps the stepped cells still.
      ref_v = 16'(512);
      repeat (3) tick();
      h1 = cell_a(1);
      h2 = cell_a(2);
      hb = cell_b(1);
      prev = int'(phase_a);
      repeat (60) begin
         tick();
         chk("R9", "A cell1 held", cell_a(1), h1);
         chk("R9", "A cell2 held", cell_a(2), h2);
         chk("R9", "B cell1 held", cell_b(1), hb);
         chk("R9", "A phase single step",
             int'((int'(phase_a) - prev) <= 2 && (int'(phase_a) - prev) >= -2), 1);
         prev = int'(phase_a);
      end

      // Sine sweeps at three amplitudes.
      foreach (ST_A[s]) begin
         if (s < 3) begin
            real ma;
            ma = (s == 0) ? 0.3 : ((s == 1) ? 0.7 : 1.0);
            for (int k = 0; k < 1024; k++) begin
               ref_v = 16'(int'(ma * 7.5 * ONE * $sin(6.283185307179586 * k / 1024.0)));
               tick();
            end
         end
      end

      // R10: saturation at both ends.
      ref_v = 16'(25600);
      repeat (3) tick();
      chk("R10", "A phase at top", int'(phase_a), 15);
      chk("R10", "B phase at top", int'(phase_b), 8);
      chk("R10", "A top cell at top", cell_a(2), 12);
      ref_v = -16'(25600);
      repeat (3) tick();
      chk("R10", "A phase at bottom", int'(phase_a), -15);
      chk("R10", "B phase at bottom", int'(phase_b), -8);
      chk("R10", "B top cell at bottom", cell_b(1), -6);

      // R1: reset in mid-run, then carrier restart is tracked by the model.
      ref_v = 16'(300);
      repeat (37) tick();
      rst_n = 1'b0;
      repeat (2) tick();
      check_reset();
      rst_n = 1'b1;
      hold(300, 150);
      hold(-64, 150);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule